// File: doc/BRIEF.md
# Slot-Based Power Rail Sequencer

This block drives nine enable lines in a fixed time order when a system powers up, and drops them in a second, independent order when it powers down. Each enable line carries two slot numbers, one for the rising direction and one for the falling direction. A walker steps through sixteen numbered slots. On entering a slot, it changes every line that belongs to that slot in a single clock cycle. It then holds for that slot's programmed delay before it enters the next slot.

The delay is a 2-bit code per slot and per direction. Each code selects a count of ticks of a prescaled timebase. The walker only counts time. It never waits for a rail to settle. Configuration is written through a simple register port while the walker is idle or parked fully on. A power-down request can cut a power-up short, and then the falling walk starts over from slot 0.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, all bits of `rail_en` are low and `up_done` is low.
- R2: An `up_req` sampled high with the block fully off starts power-up. At that same clock edge, every line whose on-slot is 0 goes high.
- R3: During power-up, slot k is entered at the sum of the durations of slots 0 to k-1, counted from the starting edge. Every line whose on-slot is k goes high at that edge, in the same cycle as all others in slot k. During power-up no line ever falls.
- R4: A slot whose code is c lasts PRESCALE*DLYc clock cycles, where DLY0 to DLY3 are tick-count parameters and code 3 is the longest.
- R5: The duration code of slot s is held in register base+(s/4), at bits [7-2*(s%4) : 6-2*(s%4)]. Slot 0 is in bits 7-6 and slot 3 is in bits 1-0. The power-up bank starts at address 9 and the power-down bank starts at address 13.
- R6: Register i (0 to 8) holds the on-slot of `rail_en[i]` in bits 7-4 and its off-slot in bits 3-0. Bits 0-2 are the buck enables, bits 3-4 the LDO enables, bits 5-6 the general outputs and bit 7 the GPIO. Bit 8 is the reset release, where 1 means reset is released.
- R7: `up_done` rises at the edge that ends slot 15 of power-up. It stays high until a power-down starts.
- R8: A `dn_req` while fully on runs slots 0 to 15 using the off-slot map, with the same timing rule as R3 and the power-down duration bank. Each line falls on entering its off-slot. After slot 15 the block is off and accepts `up_req` again. No line rises during power-down.
- R9: A `dn_req` during power-up aborts it at that edge and starts power-down at slot 0. Lines that were never enabled stay low, and `up_done` stays low.
- R10: Register writes are dropped while a sequence is running. Writes made while off or fully on are kept and used by the next sequence.
- R11: `up_req` is ignored while fully on and during power-down. `dn_req` is ignored while off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Power-up request, level sampled each cycle |
| dn_req | input | 1 | Power-down request, level sampled each cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 8 | Register write data |
| rail_en | output | NUM_OUT | Registered enable lines (bit 8 is the reset release) |
| up_done | output | 1 | Power-up sequence complete |

## Verification
The bench compares every output in every cycle of each sequence against slot entry times that it computes from the programmed codes. A walker that is off by one cycle per slot, or that reads a code from the wrong bit pair, would drift against those times. Shared slots, slot 15 and slot 0 are all exercised, so a design that staggers lines within a slot or never reaches the last slot would show a missing or late edge. An abort part way through power-up checks that lines not yet enabled stay low and that `up_done` never rises, which catches a design that finishes the up walk first. Writes made mid-sequence must leave both the current and the next sequence unchanged, while writes made when fully on must show up in the next power-down.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_UP   = 2'd1,
    SQ_ON   = 2'd2,
    SQ_DOWN = 2'd3
  } sq_state_e;

  // low bit of the 2-bit duration field for a slot inside its register
  function automatic int unsigned code_lsb(input int unsigned slot);
    return 6 - 2 * (slot % 4);
  endfunction

endpackage

// File: rtl/rseq_cfg.sv
module rseq_cfg #(
  parameter int NUM_OUT   = 9,
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 4,
  parameter int ADDR_W    = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              busy,
  input  logic                              cfg_we,
  input  logic [ADDR_W-1:0]                 cfg_addr,
  input  logic [7:0]                        cfg_wdata,
  output logic [NUM_OUT-1:0][SLOT_W-1:0]    on_slot,
  output logic [NUM_OUT-1:0][SLOT_W-1:0]    off_slot,
  output logic [NUM_SLOTS-1:0][1:0]         up_code,
  output logic [NUM_SLOTS-1:0][1:0]         dn_code
);
  import rseq_pkg::*;

  localparam int DUR_REGS = NUM_SLOTS / 4;
  localparam int UP_BASE  = NUM_OUT;
  localparam int DN_BASE  = NUM_OUT + DUR_REGS;
  localparam int NUM_REGS = DN_BASE + DUR_REGS;

  logic [NUM_REGS-1:0][7:0] regs_q;
  logic                     wr_ok;

  assign wr_ok = cfg_we && !busy && (cfg_addr < ADDR_W'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else if (wr_ok) begin
      regs_q[cfg_addr] <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_map
    assign on_slot[i]  = regs_q[i][4 +: SLOT_W];
    assign off_slot[i] = regs_q[i][0 +: SLOT_W];
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dur
    assign up_code[s] = regs_q[UP_BASE + s / 4][code_lsb(s) +: 2];
    assign dn_code[s] = regs_q[DN_BASE + s / 4][code_lsb(s) +: 2];
  end

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(regs_q));

endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
  parameter int PRESCALE = 1000,
  parameter int TW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] ticks_m1,
  output logic          expire
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (load) begin
      pre_q  <= PRE_TOP;
      tick_q <= ticks_m1;
    end else if (pre_q == '0) begin
      pre_q <= PRE_TOP;
      if (tick_q != '0) tick_q <= tick_q - 1'b1;
    end else begin
      pre_q <= pre_q - 1'b1;
    end
  end

  assign expire = (pre_q == '0) && (tick_q == '0);

  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (pre_q == PRE_TOP));

endmodule

// File: rtl/rseq_core.sv
module rseq_core #(
  parameter int NUM_OUT   = 9,
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 4,
  parameter int TW        = 4,
  parameter int DLY0      = 1,
  parameter int DLY1      = 2,
  parameter int DLY2      = 5,
  parameter int DLY3      = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           up_req,
  input  logic                           dn_req,
  input  logic [NUM_OUT-1:0][SLOT_W-1:0] on_slot,
  input  logic [NUM_OUT-1:0][SLOT_W-1:0] off_slot,
  input  logic [NUM_SLOTS-1:0][1:0]      up_code,
  input  logic [NUM_SLOTS-1:0][1:0]      dn_code,
  input  logic                           expire,
  output logic                           load,
  output logic [TW-1:0]                  ticks_m1,
  output logic [NUM_OUT-1:0]             rail_en,
  output logic                           up_done,
  output logic                           busy
);
  import rseq_pkg::*;

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  sq_state_e          st_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [NUM_OUT-1:0] en_q;
  logic               done_q;

  logic               start_up, start_dn, walking, advance, at_last;
  logic               go_up, go_dn;
  logic [SLOT_W-1:0]  tgt_slot;
  logic [1:0]         code;
  logic [NUM_OUT-1:0] on_hit, off_hit;

  always_comb begin
    walking  = (st_q == SQ_UP) || (st_q == SQ_DOWN);
    start_up = (st_q == SQ_OFF) && up_req;
    start_dn = ((st_q == SQ_ON) || (st_q == SQ_UP)) && dn_req;
    advance  = walking && expire && !start_dn;
    at_last  = (slot_q == LAST);
    tgt_slot = (start_up || start_dn) ? '0 : slot_q + 1'b1;
    go_up    = start_up || ((st_q == SQ_UP) && advance && !at_last);
    go_dn    = start_dn || ((st_q == SQ_DOWN) && advance && !at_last);
    code     = go_up ? up_code[tgt_slot] : dn_code[tgt_slot];
  end

  always_comb begin
    case (code)
      2'd0:    ticks_m1 = TW'(DLY0 - 1);
      2'd1:    ticks_m1 = TW'(DLY1 - 1);
      2'd2:    ticks_m1 = TW'(DLY2 - 1);
      default: ticks_m1 = TW'(DLY3 - 1);
    endcase
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_hit
    assign on_hit[i]  = (on_slot[i]  == tgt_slot);
    assign off_hit[i] = (off_slot[i] == tgt_slot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_OFF;
      slot_q <= '0;
      en_q   <= '0;
      done_q <= 1'b0;
    end else if (go_dn) begin
      st_q   <= SQ_DOWN;
      slot_q <= tgt_slot;
      en_q   <= en_q & ~off_hit;
      done_q <= 1'b0;
    end else if (go_up) begin
      st_q   <= SQ_UP;
      slot_q <= tgt_slot;
      en_q   <= en_q | on_hit;
    end else if (advance && at_last) begin
      st_q   <= (st_q == SQ_UP) ? SQ_ON : SQ_OFF;
      done_q <= (st_q == SQ_UP);
    end
  end

  assign load    = go_up || go_dn;
  assign rail_en = en_q;
  assign up_done = done_q;
  assign busy    = walking;

  assert_up_no_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_UP && !dn_req) |=> (($past(en_q) & ~en_q) == '0));

  assert_slot_step_R3: assert property (@(posedge clk) disable iff (rst)
    (walking && st_q == $past(st_q)) |->
      (slot_q == $past(slot_q) || slot_q == $past(slot_q) + 1'b1));

  assert_down_no_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_DOWN) |=> ((en_q & ~$past(en_q)) == '0));

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_OFF) |-> (en_q == '0 && !done_q));

  assert_done_from_up_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ($past(st_q) == SQ_UP && st_q == SQ_ON));

  assert_abort_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_UP && dn_req) |=> (st_q == SQ_DOWN && slot_q == '0 && !done_q));

endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top #(
  parameter int NUM_OUT   = 9,
  parameter int NUM_SLOTS = 16,
  parameter int ADDR_W    = 5,
  parameter int PRESCALE  = 1000,
  parameter int DLY0      = 1,
  parameter int DLY1      = 2,
  parameter int DLY2      = 5,
  parameter int DLY3      = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up_req,
  input  logic               dn_req,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [NUM_OUT-1:0] rail_en,
  output logic               up_done
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int TW     = $clog2(DLY3) + 1;

  logic [NUM_OUT-1:0][SLOT_W-1:0] on_slot, off_slot;
  logic [NUM_SLOTS-1:0][1:0]      up_code, dn_code;
  logic                           busy, load, expire;
  logic [TW-1:0]                  ticks_m1;

  rseq_cfg #(
    .NUM_OUT(NUM_OUT), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .busy(busy),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .on_slot(on_slot), .off_slot(off_slot), .up_code(up_code), .dn_code(dn_code)
  );

  rseq_timer #(
    .PRESCALE(PRESCALE), .TW(TW)
  ) u_timer (
    .clk(clk), .rst(rst), .load(load), .ticks_m1(ticks_m1), .expire(expire)
  );

  rseq_core #(
    .NUM_OUT(NUM_OUT), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TW(TW),
    .DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .DLY3(DLY3)
  ) u_core (
    .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req),
    .on_slot(on_slot), .off_slot(off_slot), .up_code(up_code), .dn_code(dn_code),
    .expire(expire), .load(load), .ticks_m1(ticks_m1),
    .rail_en(rail_en), .up_done(up_done), .busy(busy)
  );

endmodule

// File: tb/rail_seq_top_tb.sv
module rail_seq_top_tb;
  localparam int N  = 9;
  localparam int PS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up_req = 1'b0, dn_req = 1'b0, cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [N-1:0] rail_en;
  logic       up_done;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  int on_m[N], off_m[N], upc[16], dnc[16];
  int tk[4] = '{1, 2, 3, 5};

  always #2 clk = ~clk;

  rail_seq_top #(.PRESCALE(PS), .DLY0(1), .DLY1(2), .DLY2(3), .DLY3(5)) u_dut (
    .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rail_en(rail_en), .up_done(up_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int entry(input bit up, input int k);
    int sum = 0;
    for (int j = 0; j < k; j++) sum += PS * tk[up ? upc[j] : dnc[j]];
    return sum;
  endfunction

  function automatic logic [N-1:0] exp_vec(input bit up, input logic [N-1:0] st, input int t);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = up ? (st[i] | (entry(1, on_m[i]) <= t)) : (st[i] & (entry(0, off_m[i]) > t));
    return v;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog();
    for (int i = 0; i < N; i++) wr(i, (on_m[i] << 4) | off_m[i]);
    for (int r = 0; r < 4; r++) begin
      wr(9 + r,  (upc[4*r] << 6) | (upc[4*r+1] << 4) | (upc[4*r+2] << 2) | upc[4*r+3]);
      wr(13 + r, (dnc[4*r] << 6) | (dnc[4*r+1] << 4) | (dnc[4*r+2] << 2) | dnc[4*r+3]);
    end
  endtask

  // t counts samples after the edge that took the request (t=0 first)
  task automatic run_seq(input bit up, input logic [N-1:0] st, input int t0, input int t1,
                         input string req);
    for (int t = t0; t <= t1; t++) begin
      @(negedge clk);
      up_req = 1'b0; dn_req = 1'b0; cfg_we = 1'b0;
      chk(req, 32'(rail_en), 32'(exp_vec(up, st, t)));
      chk({req, " done"}, 32'(up_done), 32'(up && t >= entry(1, 16)));
    end
  endtask

  task automatic full_cycle(input string req_up, input string req_dn);
    @(negedge clk); up_req = 1'b1;
    run_seq(1, '0, 0, entry(1, 16), req_up);
    dn_req = 1'b1;
    run_seq(0, '1, 0, entry(0, 16), req_dn);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rail_en", 32'(rail_en), 0);
    chk("R1 up_done", 32'(up_done), 0);

    // R2 R3 R6 R7 R8: staircase map, every code 0
    for (int i = 0; i < N; i++) begin on_m[i] = i; off_m[i] = 8 - i; end
    for (int s = 0; s < 16; s++) begin upc[s] = 0; dnc[s] = 0; end
    prog();
    full_cycle("R2/R3 staircase up", "R8 staircase down");

    // R4: uniform code sweep over all four codes
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < N; i++) begin on_m[i] = (i * 2) % 16; off_m[i] = 15 - i; end
      for (int s = 0; s < 16; s++) begin upc[s] = c; dnc[s] = 3 - c; end
      prog();
      full_cycle("R4 code sweep up", "R4 code sweep down");
    end

    // R5 R3: mixed per-slot codes, shared slots, slot 15 in use
    on_m  = '{0, 15, 3, 3, 7, 15, 0, 9, 12};
    off_m = '{15, 0, 5, 5, 2, 15, 8, 8, 1};
    for (int s = 0; s < 16; s++) begin upc[s] = (s * 3 + 1) % 4; dnc[s] = (s + 2) % 4; end
    prog();
    full_cycle("R5 packed up", "R5 packed down");

    // R11: dn_req while off ignored
    @(negedge clk); dn_req = 1'b1;
    run_seq(0, '0, 0, 5, "R11 dn while off");
    // R11: up_req while on ignored, up_req during down ignored
    @(negedge clk); up_req = 1'b1;
    run_seq(1, '0, 0, entry(1, 16), "R11 up run");
    up_req = 1'b1;
    run_seq(1, '0, entry(1, 16), entry(1, 16) + 6, "R11 up while on");
    dn_req = 1'b1;
    run_seq(0, '1, 0, 3, "R11 down run");
    up_req = 1'b1;
    run_seq(0, '1, 4, entry(0, 16), "R11 up during down");

    // R9: abort at several points of power-up
    for (int k = 0; k < 3; k++) begin
      int a;
      a = (k == 0) ? 1 : (k == 1) ? 20 : entry(1, 15) + 1;
      @(negedge clk); up_req = 1'b1;
      run_seq(1, '0, 0, a - 1, "R9 pre-abort");
      dn_req = 1'b1;
      run_seq(0, exp_vec(1, '0, a - 1), 0, entry(0, 16), "R9 abort down");
    end

    // R10: write during a sequence dropped, now and for the next sequence
    @(negedge clk); up_req = 1'b1;
    run_seq(1, '0, 0, 2, "R10 up");
    cfg_we = 1'b1; cfg_addr = 5'd1; cfg_wdata = 8'h00;
    run_seq(1, '0, 3, entry(1, 16), "R10 write mid up");
    dn_req = 1'b1;
    run_seq(0, '1, 0, 2, "R10 down");
    cfg_we = 1'b1; cfg_addr = 5'd9; cfg_wdata = 8'hFF;
    run_seq(0, '1, 3, entry(0, 16), "R10 write mid down");
    @(negedge clk); up_req = 1'b1;
    run_seq(1, '0, 0, entry(1, 16), "R10 next up old cfg");
    // write while on is kept: output 1 now leaves at slot 6
    on_m[1] = 2; off_m[1] = 6;
    wr(1, 8'h26);
    dn_req = 1'b1;
    run_seq(0, '1, 0, entry(0, 16), "R10 write while on");
    @(negedge clk); up_req = 1'b1;
    run_seq(1, '0, 0, entry(1, 16), "R10 R6 new map up");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule